// File: doc/BRIEF.md
# Wide Performance Counter and Time Register Unit

This unit holds four 64-bit machine registers: a cycle counter, a retired-instruction counter, a read-only mirror of the platform time, and a read-write time offset used by guests. Software reaches them through one CSR port made up of a small register index, a write enable, write data and combinational read data. The pipeline supplies how many instructions retired in each cycle. A platform timer pushes the current time in through a sync strobe.

A mode input selects the register width. In 32-bit mode each register appears as a low word and a high word, and the two words can be written separately. In 64-bit mode the low index of each pair covers the whole value. When the virtualization input is high, a read of time returns the mirrored time plus the offset register. The sum wraps modulo 2^64. Permission checks are made by another block.

Top module: `ctr_csr_unit`

## Requirements
- R1: Index map on `csr_addr_i`: 0 cycle low, 1 cycle high, 2 instret low, 3 instret high, 4 time low, 5 time high, 6 offset low, 7 offset high. Indices 8 to 15 read zero and ignore writes. While reset is held, every register reads zero.
- R2: The cycle counter adds one on every clock edge, except an edge at which software writes it. A write that lands takes the written value with no increment.
- R3: The instret counter adds `retire_cnt_i` on every edge. A software write in the same cycle wins, and that cycle's increment is dropped.
- R4: In 32-bit mode (`rv32_i`=1), a write to a low index replaces bits 31:0 with `csr_wdata_i[31:0]` and keeps bits 63:32.
- R5: In 32-bit mode, a write to a high index replaces bits 63:32 with `csr_wdata_i[31:0]` and keeps bits 31:0.
- R6: In 32-bit mode, a read of a low index returns bits 31:0 zero-extended, and a read of a high index returns bits 63:32 zero-extended.
- R7: In 64-bit mode, the low index reads and writes all 64 bits. High indices read zero and ignore writes.
- R8: The time register ignores software writes. It loads `time_sync_i` on an edge where `time_sync_valid_i`=1 and otherwise holds its value.
- R9: When `virt_i`=1, a read of time returns (time + offset) mod 2^64, and its high index returns bits 63:32 of that sum. When `virt_i`=0, the read returns time alone.
- R10: The offset register resets to zero, is plain read-write storage and never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rv32_i | input | 1 | 1 selects the split 32-bit view |
| virt_i | input | 1 | Guest context; adds the offset to time reads |
| csr_addr_i | input | 4 | Register index |
| csr_we_i | input | 1 | Write enable |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data, combinational from index |
| retire_cnt_i | input | 2 | Instructions retired this cycle |
| time_sync_valid_i | input | 1 | Strobe to load time |
| time_sync_i | input | 64 | Platform time value |

## Verification
A write, a retire count or a time sync takes effect at the next rising edge. Read data is combinational, so each result can be seen one edge after its stimulus. The bench drives stimulus on the falling edge, lets one rising edge pass, then clears the write, retire and sync inputs on the next falling edge and samples the read 1 ns later. The free-running cycle counter is checked the same way, adding one expected count for every further rising edge the bench steps through.

// File: rtl/ctr_csr_pkg.sv
package ctr_csr_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned HALF   = XLEN / 2;
  localparam int unsigned AW     = 4;
  localparam int unsigned RET_W  = 2;
  localparam int unsigned NREG_W = 3;  // registers with software write path

  localparam logic [AW-1:0] IDX_CYC = 4'd0;
  localparam logic [AW-1:0] IDX_RET = 4'd2;
  localparam logic [AW-1:0] IDX_TIM = 4'd4;
  localparam logic [AW-1:0] IDX_DLT = 4'd6;

  typedef enum logic [1:0] {SRC_CYC = 2'd0, SRC_RET = 2'd1, SRC_TIM = 2'd2, SRC_DLT = 2'd3} src_e;
endpackage

// File: rtl/ctr_wide_reg.sv
module ctr_wide_reg #(
  parameter int unsigned XW = 64,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] inc_i,
  input  logic          wr_full_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [XW-1:0] wdata_i,
  output logic [XW-1:0] val_o
);
  localparam int unsigned HW = XW / 2;

  logic [XW-1:0] val_q, val_d;

  // software write beats increment
  always_comb begin
    if (wr_full_i)    val_d = wdata_i;
    else if (wr_lo_i) val_d = {val_q[XW-1:HW], wdata_i[HW-1:0]};
    else if (wr_hi_i) val_d = {wdata_i[HW-1:0], val_q[HW-1:0]};
    else              val_d = val_q + XW'(inc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/ctr_time_view.sv
module ctr_time_view #(
  parameter int unsigned XW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_vld_i,
  input  logic [XW-1:0] sync_val_i,
  input  logic          virt_i,
  input  logic [XW-1:0] delta_i,
  output logic [XW-1:0] raw_o,
  output logic [XW-1:0] view_o
);
  logic [XW-1:0] tim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tim_q <= '0;
    else if (sync_vld_i) tim_q <= sync_val_i;
  end

  assign raw_o  = tim_q;
  assign view_o = virt_i ? tim_q + delta_i : tim_q;  // wraps mod 2^XW
endmodule

// File: rtl/ctr_read_mux.sv
module ctr_read_mux
  import ctr_csr_pkg::*;
#(
  parameter int unsigned XW = XLEN
) (
  input  logic          rv32_i,
  input  logic [AW-1:0] addr_i,
  input  logic [XW-1:0] cyc_i,
  input  logic [XW-1:0] ret_i,
  input  logic [XW-1:0] tim_i,
  input  logic [XW-1:0] dlt_i,
  output logic [XW-1:0] rdata_o
);
  localparam int unsigned HW = XW / 2;

  logic          in_map;
  src_e          src;
  logic [XW-1:0] sel;

  assign in_map = (addr_i >> 1) < AW'(4);
  assign src    = src_e'(addr_i[2:1]);

  always_comb begin
    unique case (src)
      SRC_CYC: sel = cyc_i;
      SRC_RET: sel = ret_i;
      SRC_TIM: sel = tim_i;
      default: sel = dlt_i;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      if (rv32_i)          rdata_o = addr_i[0] ? {{HW{1'b0}}, sel[XW-1:HW]} : {{HW{1'b0}}, sel[HW-1:0]};
      else if (!addr_i[0]) rdata_o = sel;
    end
  end
endmodule

// File: rtl/ctr_csr_unit.sv
module ctr_csr_unit
  import ctr_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rv32_i,
  input  logic             virt_i,
  input  logic [AW-1:0]    csr_addr_i,
  input  logic             csr_we_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  input  logic [RET_W-1:0] retire_cnt_i,
  input  logic             time_sync_valid_i,
  input  logic [XLEN-1:0]  time_sync_i
);
  localparam logic [AW-1:0] BASE [NREG_W] = '{IDX_CYC, IDX_RET, IDX_DLT};

  logic [NREG_W-1:0][RET_W-1:0] inc;
  logic [NREG_W-1:0][XLEN-1:0]  val;
  logic [XLEN-1:0]              tim_raw, tim_view;

  assign inc[0] = RET_W'(1);
  assign inc[1] = retire_cnt_i;
  assign inc[2] = '0;

  for (genvar g = 0; g < NREG_W; g++) begin : g_reg
    logic lo_hit, hi_hit;
    assign lo_hit = csr_addr_i == BASE[g];
    assign hi_hit = csr_addr_i == BASE[g] + AW'(1);
    ctr_wide_reg #(.XW(XLEN), .IW(RET_W)) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc[g]),
      .wr_full_i (csr_we_i & ~rv32_i & lo_hit),
      .wr_lo_i   (csr_we_i &  rv32_i & lo_hit),
      .wr_hi_i   (csr_we_i &  rv32_i & hi_hit),
      .wdata_i   (csr_wdata_i),
      .val_o     (val[g])
    );
  end

  ctr_time_view #(.XW(XLEN)) u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_vld_i (time_sync_valid_i),
    .sync_val_i (time_sync_i),
    .virt_i     (virt_i),
    .delta_i    (val[2]),
    .raw_o      (tim_raw),
    .view_o     (tim_view)
  );

  ctr_read_mux #(.XW(XLEN)) u_rmux (
    .rv32_i  (rv32_i),
    .addr_i  (csr_addr_i),
    .cyc_i   (val[0]),
    .ret_i   (val[1]),
    .tim_i   (tim_view),
    .dlt_i   (val[2]),
    .rdata_o (csr_rdata_o)
  );
endmodule

// File: rtl/ctr_csr_unit_chk.sv
module ctr_csr_unit_chk
  import ctr_csr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rv32_i,
  input logic             virt_i,
  input logic [AW-1:0]    csr_addr_i,
  input logic             csr_we_i,
  input logic [XLEN-1:0]  csr_rdata_o,
  input logic [RET_W-1:0] retire_cnt_i,
  input logic             time_sync_valid_i,
  input logic [XLEN-1:0]  cyc_v,
  input logic [XLEN-1:0]  ret_v,
  input logic [XLEN-1:0]  tim_v,
  input logic [XLEN-1:0]  dlt_v
);
  logic wr_cyc, wr_ret, wr_dlt, wr_ret_lo32;
  assign wr_cyc = csr_we_i && ((csr_addr_i == 4'd0) || (rv32_i && csr_addr_i == 4'd1));
  assign wr_ret = csr_we_i && ((csr_addr_i == 4'd2) || (rv32_i && csr_addr_i == 4'd3));
  assign wr_dlt = csr_we_i && ((csr_addr_i == 4'd6) || (rv32_i && csr_addr_i == 4'd7));
  assign wr_ret_lo32 = csr_we_i && rv32_i && csr_addr_i == 4'd2;

  AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cyc |=> cyc_v == $past(cyc_v) + 64'd1);  // R2
  AST_RET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ret |=> ret_v == $past(ret_v) + 64'($past(retire_cnt_i)));  // R3
  AST_RET_LO_KEEP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ret_lo32 |=> ret_v[63:32] == $past(ret_v[63:32]));  // R4
  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_sync_valid_i |=> $stable(tim_v));  // R8
  AST_DLT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dlt |=> $stable(dlt_v));  // R10
  AST_TIME_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rv32_i && csr_addr_i == 4'd4) |-> csr_rdata_o == (virt_i ? tim_v + dlt_v : tim_v));  // R9
  AST_HI_ZERO_64: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rv32_i && csr_addr_i[0]) |-> csr_rdata_o == '0);  // R7
endmodule

bind ctr_csr_unit ctr_csr_unit_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .rv32_i            (rv32_i),
  .virt_i            (virt_i),
  .csr_addr_i        (csr_addr_i),
  .csr_we_i          (csr_we_i),
  .csr_rdata_o       (csr_rdata_o),
  .retire_cnt_i      (retire_cnt_i),
  .time_sync_valid_i (time_sync_valid_i),
  .cyc_v             (val[0]),
  .ret_v             (val[1]),
  .tim_v             (tim_raw),
  .dlt_v             (val[2])
);

// File: tb/sim_ctr_csr_unit.sv
`timescale 1ns/1ps
module sim_ctr_csr_unit;
  typedef struct packed {
    logic        rv32;
    logic        virt;
    logic [3:0]  addr;
    logic        we;
    logic [63:0] wdata;
    logic [1:0]  ret;
    logic        sv;
    logic [63:0] sd;
    logic        crv32;
    logic [3:0]  caddr;
    logic [63:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,4'd6,1'b1,64'h1111_2222_3333_4444,2'd0,1'b0,64'h0,1'b0,4'd6,64'h1111_2222_3333_4444,4'd10}, // R10 R7
    '{1'b1,1'b0,4'd6,1'b1,64'hFFFF_FFFF_AAAA_BBBB,2'd0,1'b0,64'h0,1'b0,4'd6,64'h1111_2222_AAAA_BBBB,4'd4},  // R4
    '{1'b1,1'b0,4'd7,1'b1,64'h9999_9999_CCCC_DDDD,2'd0,1'b0,64'h0,1'b0,4'd6,64'hCCCC_DDDD_AAAA_BBBB,4'd5},  // R5
    '{1'b1,1'b0,4'd7,1'b0,64'h0,2'd0,1'b0,64'h0,1'b1,4'd7,64'h0000_0000_CCCC_DDDD,4'd6},                   // R6
    '{1'b1,1'b0,4'd6,1'b0,64'h0,2'd0,1'b0,64'h0,1'b1,4'd6,64'h0000_0000_AAAA_BBBB,4'd6},                   // R6
    '{1'b0,1'b0,4'd7,1'b1,64'h5555,2'd0,1'b0,64'h0,1'b0,4'd6,64'hCCCC_DDDD_AAAA_BBBB,4'd7},                // R7
    '{1'b0,1'b0,4'd7,1'b0,64'h0,2'd0,1'b0,64'h0,1'b0,4'd7,64'h0,4'd7},                                      // R7
    '{1'b0,1'b0,4'd0,1'b0,64'h0,2'd0,1'b1,64'h0000_0001_FFFF_FFF0,1'b0,4'd4,64'h0000_0001_FFFF_FFF0,4'd8}, // R8
    '{1'b0,1'b0,4'd4,1'b1,64'h1234,2'd0,1'b0,64'h0,1'b0,4'd4,64'h0000_0001_FFFF_FFF0,4'd8},                // R8
    '{1'b1,1'b0,4'd5,1'b1,64'h7777,2'd0,1'b0,64'h0,1'b1,4'd5,64'h1,4'd8},                                   // R8
    '{1'b0,1'b1,4'd6,1'b1,64'h20,2'd0,1'b0,64'h0,1'b0,4'd4,64'h0000_0002_0000_0010,4'd9},                  // R9
    '{1'b1,1'b1,4'd0,1'b0,64'h0,2'd0,1'b0,64'h0,1'b1,4'd5,64'h2,4'd9},                                      // R9
    '{1'b0,1'b1,4'd6,1'b1,64'hFFFF_FFFF_FFFF_FFFF,2'd0,1'b0,64'h0,1'b0,4'd4,64'h0000_0001_FFFF_FFEF,4'd9}, // R9
    '{1'b1,1'b0,4'd0,1'b0,64'h0,2'd0,1'b0,64'h0,1'b1,4'd5,64'h1,4'd9},                                      // R9
    '{1'b0,1'b0,4'd0,1'b0,64'h0,2'd3,1'b0,64'h0,1'b0,4'd2,64'h3,4'd3},                                      // R3
    '{1'b0,1'b0,4'd2,1'b1,64'h100,2'd2,1'b0,64'h0,1'b0,4'd2,64'h100,4'd3},                                  // R3
    '{1'b1,1'b0,4'd3,1'b1,64'h7,2'd1,1'b0,64'h0,1'b0,4'd2,64'h0000_0007_0000_0100,4'd5},                   // R5 R3
    '{1'b0,1'b0,4'd9,1'b1,64'hABCD,2'd0,1'b0,64'h0,1'b0,4'd9,64'h0,4'd1}                                    // R1
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rv32 = 1'b0, virt = 1'b0, we = 1'b0, sv = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0, sd = '0, rdata;
  logic [1:0]  ret = '0;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  ctr_csr_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rv32_i(rv32), .virt_i(virt),
    .csr_addr_i(addr), .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .retire_cnt_i(ret), .time_sync_valid_i(sv), .time_sync_i(sd)
  );

  task automatic check(input int rq, input logic [63:0] exp);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL R%0d addr=%0d got=%h exp=%h", rq, addr, rdata, exp);
    end
  endtask

  task automatic idle_read(input logic m32, input logic [3:0] a);
    @(negedge clk);
    we = 1'b0; sv = 1'b0; ret = '0; rv32 = m32; addr = a;
    #1;
  endtask

  initial begin
    // R1: reset state
    #2;
    addr = 4'd0; #1; check(1, 64'h0);
    addr = 4'd2; #1; check(1, 64'h0);
    addr = 4'd6; #1; check(10, 64'h0);
    addr = 4'd4; #1; check(8, 64'h0);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rv32 = VECS[i].rv32; virt = VECS[i].virt; addr = VECS[i].addr; we = VECS[i].we;
      wdata = VECS[i].wdata; ret = VECS[i].ret; sv = VECS[i].sv; sd = VECS[i].sd;
      idle_read(VECS[i].crv32, VECS[i].caddr);
      check(int'(VECS[i].rq), VECS[i].exp);
    end
    virt = 1'b0;

    // R2 R4 R5: cycle counter, split writes then carry across halves
    @(negedge clk);
    rv32 = 1'b1; we = 1'b1; addr = 4'd0; wdata = 64'hDEAD_0000_FFFF_FFFE;
    @(negedge clk);
    addr = 4'd1; wdata = 64'h0000_0000_0000_0005;
    idle_read(1'b0, 4'd0); check(2, 64'h0000_0005_FFFF_FFFE);
    idle_read(1'b0, 4'd0); check(2, 64'h0000_0005_FFFF_FFFF);
    idle_read(1'b0, 4'd0); check(2, 64'h0000_0006_0000_0000);
    idle_read(1'b1, 4'd1); check(6, 64'h0000_0000_0000_0006);
    // R7: 64-bit full write of cycle
    @(negedge clk);
    rv32 = 1'b0; we = 1'b1; addr = 4'd0; wdata = 64'h8000_0000_0000_0000;
    idle_read(1'b0, 4'd0); check(7, 64'h8000_0000_0000_0000);
    idle_read(1'b0, 4'd0); check(2, 64'h8000_0000_0000_0001);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog got=hang exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule